// File: doc/BRIEF.md
# Multiplexed ADC Channel Scan Sequencer

The sequencer walks an analog multiplexer through a contiguous run of input channels and issues one conversion request to an external converter for each accepted trigger. Software sets it up through a small 16-bit register write port: one register holds the scan interval, one loads a gain/range code for the channel currently selected, one enables the trigger sources, and a write to the fourth register is a software trigger. Three trigger sources can start a conversion: the software register, a tick from an internal pacer (optionally gated by an external level), and the rising edge of an external pin.

When a conversion request goes out, the block presents the channel number and that channel's stored range code. When the converter reports completion, the block emits a 16-bit sample that carries the source channel in its top nibble and the 12-bit result below it. To load a scan list, software points the interval at one channel, writes its range code, repeats this for each channel, and then writes the final start/end interval.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, `conv_start`, `sample_valid`, `busy` and `overrun` are 0, the scan interval is channel 0 to channel 0, and every stored range code is 0.
- R2: A write to address 0 sets the start channel from `wr_data[3:0]` (bits 7:0 form the start field) and the end channel from `wr_data[11:8]` (bits 15:8 form the end field). It also makes the start channel the next channel to be converted.
- R3: A write to address 1 stores `wr_data[4:0]` as the range code of the channel that is next to be converted. With each conversion request, `conv_range` shows the code stored for `conv_chan`.
- R4: Successive conversions step upward by one channel from the start channel. The channel after the end channel is the start channel. When the end channel is below the start channel, the count passes from 15 to 0.
- R5: One cycle after `conv_done` is seen while busy, `sample_valid` pulses for one cycle with `sample_data[15:12]` holding the converted channel and `sample_data[11:0]` holding `conv_result[11:0]`. Bits 15:12 of `conv_result` are ignored, and `busy` returns to 0.
- R6: The control register is written at address 2. Bit 0 enables software triggers, bit 1 the pacer, bit 2 the external trigger and bit 3 pacer gating. Any write to address 3 starts a conversion only when bit 0 is set.
- R7: A `pacer_tick` starts a conversion when control bit 1 is set. When bit 3 is also set, the tick counts only while `ext_gate` is 1.
- R8: With control bit 2 set, a rising edge on `ext_trig` starts exactly one conversion, however long the pin stays high.
- R9: A trigger that arrives while a conversion is in progress is ignored: the channel does not advance, and the sticky `overrun` flag is set. A write to the control register clears `overrun`.
- R10: A trigger in the same cycle as `conv_done` is accepted. It produces the sample and a new request together and does not set `overrun`.
- R11: With control bits 2:0 all zero, no trigger starts a conversion and the next channel is held.
- R12: `conv_start` is a single-cycle pulse in the cycle after the accepted trigger. A `conv_done` while not busy produces no sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 interval, 1 range, 2 control, 3 soft trigger |
| wr_data | input | 16 | Register write data |
| pacer_tick | input | 1 | Internal pacer pulse |
| ext_trig | input | 1 | External trigger pin (rising edge) |
| ext_gate | input | 1 | External gate level for the pacer |
| conv_done | input | 1 | Converter completion pulse |
| conv_result | input | 16 | Converter result; low 12 bits used |
| conv_start | output | 1 | Conversion request pulse |
| conv_chan | output | 4 | Multiplexer channel for the request |
| conv_range | output | 5 | Range code for the request |
| sample_valid | output | 1 | Sample word valid pulse |
| sample_data | output | 16 | Channel tag and conversion result |
| busy | output | 1 | Conversion in progress |
| overrun | output | 1 | Sticky flag for a trigger that was dropped |

## Verification
Completion of a conversion and the arrival of the next trigger can fall in the same cycle. The bench provokes this by pulsing `conv_done` together with a software-trigger write. It then expects a sample tagged with the old channel, a fresh request for the next channel in scan order, `busy` still high and `overrun` still low. The contrasting case, a trigger one cycle before completion, must instead be dropped and must raise `overrun`.

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int CH_W    = 4,
  parameter int RES_W   = 12,
  parameter int RANGE_W = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [1:0]                wr_addr,
  input  logic [CH_W+RES_W-1:0]     wr_data,
  input  logic                      pacer_tick,
  input  logic                      ext_trig,
  input  logic                      ext_gate,
  input  logic                      conv_done,
  input  logic [CH_W+RES_W-1:0]     conv_result,
  output logic                      conv_start,
  output logic [CH_W-1:0]           conv_chan,
  output logic [RANGE_W-1:0]        conv_range,
  output logic                      sample_valid,
  output logic [CH_W+RES_W-1:0]     sample_data,
  output logic                      busy,
  output logic                      overrun
);
  localparam int NCH    = 1 << CH_W;
  localparam int FLD_W  = (CH_W + RES_W) / 2;
  localparam logic [1:0] A_MUX = 2'd0, A_RNG = 2'd1, A_CTL = 2'd2, A_SWT = 2'd3;

  logic [CH_W-1:0]    scan_lo, scan_hi, cur, act_chan;
  logic [RANGE_W-1:0] rng_mem [NCH];
  logic [3:0]         ctl;
  logic               ext_q;

  wire mux_wr = wr_en && wr_addr == A_MUX;
  wire rng_wr = wr_en && wr_addr == A_RNG;
  wire ctl_wr = wr_en && wr_addr == A_CTL;
  wire swt_wr = wr_en && wr_addr == A_SWT;

  wire pace_ok = pacer_tick && (!ctl[3] || ext_gate);
  wire trig    = (ctl[0] && swt_wr) || (ctl[1] && pace_ok) || (ctl[2] && ext_trig && !ext_q);
  wire done_ok = conv_done && busy;
  wire accept  = trig && (!busy || conv_done);
  wire ovr_set = trig && busy && !conv_done;

  wire [CH_W-1:0] nxt = (cur == scan_hi) ? scan_lo : cur + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_lo      <= '0;
      scan_hi      <= '0;
      cur          <= '0;
      act_chan     <= '0;
      ctl          <= '0;
      ext_q        <= 1'b0;
      conv_start   <= 1'b0;
      conv_chan    <= '0;
      conv_range   <= '0;
      sample_valid <= 1'b0;
      sample_data  <= '0;
      busy         <= 1'b0;
      overrun      <= 1'b0;
      for (int i = 0; i < NCH; i++) rng_mem[i] <= '0;
    end else begin
      ext_q        <= ext_trig;
      conv_start   <= accept;
      sample_valid <= done_ok;
      if (done_ok) sample_data <= {act_chan, conv_result[RES_W-1:0]};
      if (accept) begin
        busy       <= 1'b1;
        act_chan   <= cur;
        conv_chan  <= cur;
        conv_range <= rng_mem[cur];
      end else if (done_ok) begin
        busy <= 1'b0;
      end
      if (mux_wr) begin
        scan_lo <= wr_data[CH_W-1:0];
        scan_hi <= wr_data[FLD_W +: CH_W];
        cur     <= wr_data[CH_W-1:0];
      end else if (accept) begin
        cur <= nxt;
      end
      if (rng_wr) rng_mem[cur] <= wr_data[RANGE_W-1:0];
      if (ctl_wr) ctl <= wr_data[3:0];
      if (ovr_set) overrun <= 1'b1;
      else if (ctl_wr) overrun <= 1'b0;
    end
  end

  a_r12_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);
  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ctl_wr) |=> overrun);
  a_r5_sample_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> $past(conv_done));
  a_r11_idle_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[2:0] == 3'b000) |=> !conv_start);
  a_r9_busy_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_done) |=> !conv_start);
  a_r12_idle_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy) |=> !sample_valid);
endmodule

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0; logic [1:0] wr_addr = 0; logic [15:0] wr_data = 0;
  logic pacer_tick = 0, ext_trig = 0, ext_gate = 0, conv_done = 0;
  logic [15:0] conv_result = 0;
  logic conv_start, sample_valid, busy, overrun;
  logic [3:0] conv_chan; logic [4:0] conv_range; logic [15:0] sample_data;

  adc_scan_seq uut (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .pacer_tick, .ext_trig,
    .ext_gate, .conv_done, .conv_result, .conv_start, .conv_chan, .conv_range,
    .sample_valid, .sample_data, .busy, .overrun);

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [3:0] m_lo = 0, m_hi = 0, m_cur = 0;
  logic [4:0] m_rng [16];

  function automatic logic [3:0] nxt_ch(logic [3:0] c, logic [3:0] lo, logic [3:0] hi);
    return (c == hi) ? lo : c + 4'd1;
  endfunction

  function automatic logic [15:0] exp_sample(logic [3:0] ch, logic [15:0] r);
    return {ch, r[11:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(); @(posedge clk); #1; endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; step(); wr_en = 0;
    if (a == 0) begin m_lo = d[3:0]; m_hi = d[11:8]; m_cur = d[3:0]; end
    if (a == 1) m_rng[m_cur] = d[4:0];
  endtask

  task automatic finish_conv(input logic [3:0] tag, input string req);
    logic [15:0] r;
    r = 16'($urandom);
    repeat ($urandom_range(0, 2)) step();
    conv_done = 1; conv_result = r; step(); conv_done = 0;
    chk(sample_valid === 1'b1, req, sample_valid, 1);
    chk(sample_data === exp_sample(tag, r), req, sample_data, exp_sample(tag, r));
    chk(busy === 1'b0, req, busy, 0);
    step();
    chk(sample_valid === 1'b0, "R5 pulse", sample_valid, 0);
  endtask

  task automatic start_conv(input int kind, input string req, output logic [3:0] tag);
    case (kind)
      0: begin wr(2, 16'h1); wr(3, 16'($urandom)); end
      1: begin
           if ($urandom_range(0, 1) == 1) begin wr(2, 16'hA); ext_gate = 1; end
           else wr(2, 16'h2);
           pacer_tick = 1; step(); pacer_tick = 0; ext_gate = 0;
         end
      default: begin wr(2, 16'h4); ext_trig = 1; step(); ext_trig = 0; end
    endcase
    chk(conv_start === 1'b1, req, conv_start, 1);
    chk(conv_chan === m_cur, req, conv_chan, m_cur);
    chk(conv_range === m_rng[m_cur], "R3 range", conv_range, m_rng[m_cur]);
    tag = m_cur;
    m_cur = nxt_ch(m_cur, m_lo, m_hi);
    step();
    chk(conv_start === 1'b0 && busy === 1'b1, "R12 pulse", {conv_start, busy}, 2'b01);
  endtask

  task automatic full_conv(input int kind, input string req);
    logic [3:0] t;
    start_conv(kind, req, t);
    finish_conv(t, "R5 sample");
  endtask

  task automatic load_list(input logic [3:0] lo, input logic [3:0] hi);
    for (int c = 0; c < 16; c++)
      if ($urandom_range(0, 1) == 1) begin
        wr(0, {4'h0, 4'(c), 4'h0, 4'(c)});
        wr(1, 16'($urandom));
      end
    wr(0, {4'h0, hi, 4'h0, lo});
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] t, t2;
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) m_rng[i] = 0;
    repeat (3) step();
    rst_n = 1; step();
    // R1 reset state
    chk({conv_start, sample_valid, busy, overrun} === 4'b0, "R1 reset", {conv_start, sample_valid, busy, overrun}, 0);
    // R11 / R6: no source enabled
    wr(3, 16'h0); pacer_tick = 1; step(); pacer_tick = 0;
    ext_trig = 1; step(); ext_trig = 0; step();
    chk(conv_start === 1'b0 && busy === 1'b0, "R11 idle", {conv_start, busy}, 0);
    full_conv(0, "R1 first channel 0");
    chk(conv_chan === 4'd0 && conv_range === 5'd0, "R1 reset chan/range", {conv_chan, conv_range}, 0);
    // R2 R3 R4 directed list 2..5
    for (int c = 2; c <= 5; c++) begin
      wr(0, {4'h0, 4'(c), 4'h0, 4'(c)}); wr(1, 16'hFFE0 | 16'(c * 3));
    end
    wr(0, 16'h0502);
    for (int k = 0; k < 6; k++) full_conv(k % 3, "R2/R4 scan order");
    // R4 wrap modulo 16
    wr(0, 16'h010E);
    for (int k = 0; k < 5; k++) full_conv(k % 3, "R4 wrap 15->0");
    // R6 soft trigger disabled
    wr(2, 16'h2); wr(3, 16'h1); step();
    chk(conv_start === 1'b0 && busy === 1'b0, "R6 soft disabled", {conv_start, busy}, 0);
    // R11 held channel
    wr(2, 16'h0); wr(3, 16'h0); pacer_tick = 1; ext_trig = 1; step(); pacer_tick = 0; ext_trig = 0; step();
    chk(busy === 1'b0, "R11 idle", busy, 0);
    full_conv(0, "R11 channel held");
    // R7 gating
    wr(2, 16'hA); ext_gate = 0; pacer_tick = 1; step(); pacer_tick = 0; step();
    chk(conv_start === 1'b0 && busy === 1'b0, "R7 gate closed", {conv_start, busy}, 0);
    ext_gate = 1; pacer_tick = 1; step(); pacer_tick = 0; ext_gate = 0;
    chk(conv_start === 1'b1 && conv_chan === m_cur, "R7 gate open", conv_chan, m_cur);
    t = m_cur; m_cur = nxt_ch(m_cur, m_lo, m_hi);
    finish_conv(t, "R7 sample");
    // R8 level held high gives one start only
    wr(2, 16'h4); ext_trig = 1; step();
    chk(conv_start === 1'b1, "R8 edge", conv_start, 1);
    t = m_cur; m_cur = nxt_ch(m_cur, m_lo, m_hi);
    repeat (3) step();
    chk(conv_start === 1'b0 && overrun === 1'b0, "R8 one start", {conv_start, overrun}, 0);
    ext_trig = 0;
    finish_conv(t, "R8 sample");
    // R9 overrun
    start_conv(0, "R9 start", t);
    wr(3, 16'h0); step();
    chk(overrun === 1'b1 && conv_start === 1'b0, "R9 overrun", {overrun, conv_start}, 2'b10);
    finish_conv(t, "R9 sample");
    chk(overrun === 1'b1, "R9 sticky", overrun, 1);
    full_conv(1, "R9 channel not advanced");
    wr(2, 16'h1);
    chk(overrun === 1'b0, "R9 clear", overrun, 0);
    // R10 trigger together with done
    start_conv(0, "R10 start", t);
    conv_done = 1; conv_result = 16'hABCD; wr_en = 1; wr_addr = 3; step(); conv_done = 0; wr_en = 0;
    chk(sample_valid === 1'b1 && sample_data === exp_sample(t, 16'hABCD), "R10 sample", sample_data, exp_sample(t, 16'hABCD));
    chk(conv_start === 1'b1 && conv_chan === m_cur && busy === 1'b1 && overrun === 1'b0,
        "R10 restart", {conv_start, conv_chan, busy, overrun}, {1'b1, m_cur, 1'b1, 1'b0});
    t2 = m_cur; m_cur = nxt_ch(m_cur, m_lo, m_hi); step();
    finish_conv(t2, "R10 second sample");
    // R12 done while idle
    conv_done = 1; conv_result = 16'h1234; step(); conv_done = 0; step();
    chk(sample_valid === 1'b0 && busy === 1'b0, "R12 idle done", {sample_valid, busy}, 0);
    // random mix
    for (int it = 0; it < 30; it++) begin
      load_list(4'($urandom), 4'($urandom));
      repeat ($urandom_range(1, 6)) full_conv($urandom_range(0, 2), "R4 random scan");
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule